// File: doc/BRIEF.md
# Template Mismatch Counter with Reject

This block scores an unknown binary edge image against a series of stored binary templates, one template per pass over the image. Each beat carries eight pixels of the unknown plane and the eight matching pixels of the current template plane. The block marks every pixel where the two planes disagree. When cleaning is enabled, it drops any mismatch whose left-hand neighbour on the same line is not a mismatch too. This removes lone dots left by spatial quantisation. The surviving mismatches are counted over the whole pass.

At the end of each pass the block reports the pass score and the template number. It also keeps the lowest score seen in the current search and the template that gave it. Its reject flag says whether that best score is still above a threshold set by the user. The user runs a search by sending one pass per template. The first pass of a search carries a new-search flag. Positioning of the image is done upstream.

The pixel stream uses valid/ready. A beat moves when `s_valid` and `s_ready` are both high, and the upstream must hold its beat stable while `s_ready` is low. The result is a single-entry output that also uses valid/ready. While a result waits to be taken, `s_ready` stays low, so each pass costs one extra cycle at least.

Top module: `tm_match_top`

## Requirements
- R1: With cleaning off, the pass score is the number of pixel positions in the pass where the unknown bit differs from the template bit.
- R2: In each beat, bit 7 is the leftmost pixel and bit 0 the rightmost. With cleaning on, a mismatch counts only if the pixel just to its left on the same line is also a mismatch. The first pixel of each line has a left neighbour of 0, and pixels never pair across a line end.
- R3: The cleaning enable is sampled on the first beat of a pass and holds for the whole pass. Changes to it later in the pass have no effect.
- R4: The score saturates at 2^CNT_W-1 and never wraps.
- R5: A beat with `s_sop` high starts a pass, and the pass closes after IMG_W/8*IMG_H beats. Beats accepted while no pass is open are discarded and produce no result.
- R6: The template index is 0 for a pass whose first beat has `s_new_search` high. Each later pass gets the previous index plus one.
- R7: The best score is the lowest pass score since the search began. On a tie the earlier index is kept. A new search discards the old best.
- R8: At the end of each pass, `reject` becomes 1 exactly when the best score is greater than `cfg_threshold` as sampled on the pass's last beat. An equal score does not reject.
- R9: `res_valid` rises one cycle after the last beat of a pass. It and the result fields stay stable until taken with `res_ready`, and `s_ready` is low while `res_valid` is high.
- R10: After reset, `s_ready` is 1 and `res_valid`, `reject`, `best_count` and `best_index` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Pixel beat valid |
| s_ready | output | 1 | Pixel beat accepted when high with s_valid |
| s_sop | input | 1 | Beat is the first of a pass |
| s_new_search | input | 1 | With s_sop: this pass starts a new search |
| s_unk | input | 8 | Unknown image pixels, bit 7 leftmost |
| s_tpl | input | 8 | Template pixels, bit 7 leftmost |
| cfg_denoise | input | 1 | Enable isolated-dot cleaning |
| cfg_threshold | input | CNT_W | Reject limit for the best score |
| res_valid | output | 1 | Pass result available |
| res_ready | input | 1 | Result taken |
| res_count | output | CNT_W | Score of the finished pass |
| res_index | output | IDX_W | Template index of the finished pass |
| best_count | output | CNT_W | Lowest score in the current search |
| best_index | output | IDX_W | Template index of the lowest score |
| reject | output | 1 | Best score above threshold |

## Verification
The bench runs passes with no mismatch, with lone dots, with dot pairs and with full planes. Comparing each of these with cleaning on and off shows that the cleaning step drops only isolated dots. Pairs that straddle two bytes on one line are kept, while pairs that straddle a line end are dropped, which shows that the carried neighbour resets at each line. Score sequences with a tie, a later higher-scoring new search, and scores just above and equal to the threshold show that the selection rule and the strict comparison are right. A full plane with cleaning off shows the saturation. Stray beats outside a pass are also sent, to check that they leave no trace.

// File: rtl/tm_pkg.sv
package tm_pkg;
  // number of set bits in the low n bits of v
  function automatic int unsigned ones_in(input logic [31:0] v, input int unsigned n);
    int unsigned c;
    c = 0;
    for (int unsigned k = 0; k < 32; k++)
      if (k < n && v[k]) c++;
    return c;
  endfunction
endpackage

// File: rtl/tm_xor_clean.sv
module tm_xor_clean #(
  parameter int PB = 8
) (
  input  logic [PB-1:0] unk,
  input  logic [PB-1:0] tpl,
  input  logic          left_in,
  input  logic          clean_en,
  output logic [PB-1:0] diff,
  output logic [PB-1:0] kept
);
  // bit PB-1 is the leftmost pixel; its left neighbour arrives in left_in
  logic [PB-1:0] left_nb;
  assign diff    = unk ^ tpl;
  assign left_nb = {left_in, diff[PB-1:1]};
  assign kept    = clean_en ? (diff & left_nb) : diff;
endmodule

// File: rtl/tm_accum.sv
module tm_accum #(
  parameter int PB    = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             first,
  input  logic [PB-1:0]    bits,
  output logic [CNT_W-1:0] sum_next
);
  import tm_pkg::*;
  localparam int PC_W = $clog2(PB + 1);
  localparam logic [CNT_W-1:0] TOP_VAL = {CNT_W{1'b1}};

  logic [CNT_W-1:0] acc_q;
  logic [PC_W-1:0]  pc;
  logic [CNT_W:0]   wide;
  logic [CNT_W-1:0] base;

  assign pc   = PC_W'(ones_in(32'(bits), PB));
  assign base = first ? '0 : acc_q;
  assign wide = {1'b0, base} + (CNT_W+1)'(pc);
  assign sum_next = wide[CNT_W] ? TOP_VAL : wide[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)    acc_q <= '0;
    else if (take) acc_q <= sum_next;
  end
endmodule

// File: rtl/tm_best.sv
module tm_best #(
  parameter int CNT_W = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             done,
  input  logic [CNT_W-1:0] cnt,
  input  logic [IDX_W-1:0] idx,
  input  logic [CNT_W-1:0] thr,
  output logic [CNT_W-1:0] best_count,
  output logic [IDX_W-1:0] best_index,
  output logic             reject
);
  logic             fresh_q;
  logic             adopt;
  logic [CNT_W-1:0] new_best;

  // strict less-than keeps the earlier index on a tie
  assign adopt    = start || fresh_q || (cnt < best_count);
  assign new_best = adopt ? cnt : best_count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fresh_q    <= 1'b1;
      best_count <= '0;
      best_index <= '0;
      reject     <= 1'b0;
    end else if (done) begin
      fresh_q    <= 1'b0;
      best_count <= new_best;
      if (adopt) best_index <= idx;
      reject     <= new_best > thr;
    end else if (start) begin
      fresh_q    <= 1'b1;
    end
  end
endmodule

// File: rtl/tm_match_top.sv
module tm_match_top #(
  parameter int IMG_W = 256,
  parameter int IMG_H = 256,
  parameter int CNT_W = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic             s_sop,
  input  logic             s_new_search,
  input  logic [7:0]       s_unk,
  input  logic [7:0]       s_tpl,
  input  logic             cfg_denoise,
  input  logic [CNT_W-1:0] cfg_threshold,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [CNT_W-1:0] res_count,
  output logic [IDX_W-1:0] res_index,
  output logic [CNT_W-1:0] best_count,
  output logic [IDX_W-1:0] best_index,
  output logic             reject
);
  localparam int PB         = 8;
  localparam int LINE_BYTES = IMG_W / PB;
  localparam int PASS_BYTES = LINE_BYTES * IMG_H;
  localparam int LP_W       = $clog2(LINE_BYTES + 1);
  localparam int TP_W       = $clog2(PASS_BYTES + 1);

  logic             open_q, clean_q, left_q;
  logic [LP_W-1:0]  line_q, line_eff;
  logic [TP_W-1:0]  tot_q, tot_eff;
  logic [IDX_W-1:0] idx_q, nxt_idx_q, idx_eff;
  logic             beat, take, first, last, clean_eff, left_eff;
  logic [PB-1:0]    diff, kept;
  logic [CNT_W-1:0] sum_next;

  assign s_ready   = !res_valid;
  assign beat      = s_valid && s_ready;
  assign first     = beat && s_sop;
  assign take      = beat && (s_sop || open_q);
  assign line_eff  = first ? '0 : line_q;
  assign tot_eff   = first ? '0 : tot_q;
  assign clean_eff = first ? cfg_denoise : clean_q;
  assign left_eff  = (line_eff == '0) ? 1'b0 : left_q;
  assign idx_eff   = first ? (s_new_search ? '0 : nxt_idx_q) : idx_q;
  assign last      = take && (tot_eff == TP_W'(PASS_BYTES - 1));

  tm_xor_clean #(.PB(PB)) u_xc (
    .unk(s_unk), .tpl(s_tpl), .left_in(left_eff), .clean_en(clean_eff),
    .diff(diff), .kept(kept)
  );

  tm_accum #(.PB(PB), .CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .take(take), .first(first),
    .bits(kept), .sum_next(sum_next)
  );

  tm_best #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_best (
    .clk(clk), .rst_n(rst_n), .start(first && s_new_search), .done(last),
    .cnt(sum_next), .idx(idx_eff), .thr(cfg_threshold),
    .best_count(best_count), .best_index(best_index), .reject(reject)
  );

  // pass framing and pixel-neighbour carry
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      clean_q   <= 1'b0;
      left_q    <= 1'b0;
      line_q    <= '0;
      tot_q     <= '0;
      idx_q     <= '0;
      nxt_idx_q <= '0;
    end else if (take) begin
      open_q  <= !last;
      clean_q <= clean_eff;
      left_q  <= diff[0];
      idx_q   <= idx_eff;
      line_q  <= (line_eff == LP_W'(LINE_BYTES - 1)) ? '0 : line_eff + 1'b1;
      tot_q   <= tot_eff + 1'b1;
      if (last) nxt_idx_q <= idx_eff + 1'b1;
    end
  end

  // single-entry result holder
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_count <= '0;
      res_index <= '0;
    end else if (last) begin
      res_valid <= 1'b1;
      res_count <= sum_next;
      res_index <= idx_eff;
    end else if (res_valid && res_ready) begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tm_checker.sv
module tm_checker #(
  parameter int CNT_W = 16,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s_ready,
  input logic [CNT_W-1:0] cfg_threshold,
  input logic             res_valid,
  input logic             res_ready,
  input logic [CNT_W-1:0] res_count,
  input logic [IDX_W-1:0] res_index,
  input logic [CNT_W-1:0] best_count,
  input logic             reject
);
  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !s_ready);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_count) && $stable(res_index)));

  p_best_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (best_count <= res_count));

  p_best_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(res_valid) |-> $stable(best_count));

  p_reject_rule_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> (reject == (best_count > $past(cfg_threshold))));
endmodule

bind tm_match_top tm_checker #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_ready(s_ready), .cfg_threshold(cfg_threshold),
  .res_valid(res_valid), .res_ready(res_ready), .res_count(res_count),
  .res_index(res_index), .best_count(best_count), .reject(reject)
);

// File: tb/tb_tm_match_top.sv
module tb_tm_match_top;
  localparam int W = 16, H = 4, CW = 5, IW = 3;
  localparam int LB = W / 8, NB = LB * H;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic s_valid = 0, s_sop = 0, s_new_search = 0, cfg_denoise = 0, res_ready = 0;
  logic [7:0] s_unk = '0, s_tpl = '0;
  logic [CW-1:0] cfg_threshold = '0;
  logic s_ready, res_valid, reject;
  logic [CW-1:0] res_count, best_count;
  logic [IW-1:0] res_index, best_index;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [7:0] mis_b [NB];
  logic [7:0] tpl_b [NB];
  int eb_cnt = 0, eb_idx = 0, nxt = 0;
  bit fresh = 1;

  always #5 clk = ~clk;

  tm_match_top #(.IMG_W(W), .IMG_H(H), .CNT_W(CW), .IDX_W(IW)) dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_sop(s_sop),
    .s_new_search(s_new_search), .s_unk(s_unk), .s_tpl(s_tpl),
    .cfg_denoise(cfg_denoise), .cfg_threshold(cfg_threshold),
    .res_valid(res_valid), .res_ready(res_ready), .res_count(res_count),
    .res_index(res_index), .best_count(best_count), .best_index(best_index),
    .reject(reject)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model_count(input bit den);
    int c = 0;
    for (int ln = 0; ln < H; ln++) begin
      bit prev = 0;
      for (int b = 0; b < LB; b++)
        for (int k = 7; k >= 0; k--) begin
          bit m = mis_b[ln*LB + b][k];
          c += den ? int'(m & prev) : int'(m);
          prev = m;
        end
    end
    return (c > MAXC) ? MAXC : c;
  endfunction

  task automatic fill(input logic [7:0] v);
    for (int i = 0; i < NB; i++) begin
      mis_b[i] = v;
      tpl_b[i] = 8'(8'h3C + 8'(i * 37));
    end
  endtask

  // one pass; cleaning enable flips after the first beat to exercise R3
  task automatic run_pass(input bit ns, input bit den, input int thr, input string tag);
    int ec, ei;
    bit ej;
    ec = model_count(den);
    ei = ns ? 0 : nxt;
    nxt = (ei + 1) % (1 << IW);
    if (ns || fresh || ec < eb_cnt) begin eb_cnt = ec; eb_idx = ei; end
    fresh = 0;
    ej = eb_cnt > thr;
    for (int i = 0; i < NB; i++) begin
      @(negedge clk);
      s_valid = 1; s_sop = (i == 0); s_new_search = ns && (i == 0);
      s_tpl = tpl_b[i]; s_unk = tpl_b[i] ^ mis_b[i];
      cfg_denoise = (i == 0) ? den : !den;
      cfg_threshold = CW'(thr);
      @(posedge clk);
    end
    @(negedge clk);
    s_valid = 0; s_sop = 0; s_new_search = 0;
    check(res_valid == 1, {tag, " R9 res_valid"}, int'(res_valid), 1);
    check(res_count == ec, {tag, " R1 R2 R3 R4 count"}, int'(res_count), ec);
    check(res_index == ei, {tag, " R6 index"}, int'(res_index), ei);
    check(best_count == eb_cnt, {tag, " R7 best_count"}, int'(best_count), eb_cnt);
    check(best_index == eb_idx, {tag, " R7 best_index"}, int'(best_index), eb_idx);
    check(reject == ej, {tag, " R8 reject"}, int'(reject), int'(ej));
    res_ready = 1;
    @(negedge clk);
    res_ready = 0;
    check(res_valid == 0 && s_ready == 1, {tag, " R9 taken"}, int'(res_valid), 0);
  endtask

  task automatic t_reset();
    check(s_ready == 1, "R10 s_ready", int'(s_ready), 1);
    check(res_valid == 0, "R10 res_valid", int'(res_valid), 0);
    check(reject == 0 && best_count == 0 && best_index == 0, "R10 best/reject",
          int'(best_count), 0);
  endtask

  task automatic t_exact();
    fill(8'h00);
    run_pass(1, 0, 0, "exact R1");
  endtask

  task automatic t_dots();
    fill(8'h00);
    mis_b[0] = 8'b1010_0100; mis_b[3] = 8'b0001_0001; mis_b[5] = 8'b0110_0000;
    run_pass(1, 1, 31, "dots clean R2");   // only the 0110 pair survives: 1
    run_pass(1, 0, 31, "dots raw R1");     // 3+2+2 = 7
  endtask

  task automatic t_line_edge();
    fill(8'h00);
    mis_b[1] = 8'h01; mis_b[2] = 8'h80;    // across a line end: dropped
    run_pass(1, 1, 31, "line end R2");
    fill(8'h00);
    mis_b[0] = 8'h01; mis_b[1] = 8'h80;    // across bytes, same line: 1
    run_pass(1, 1, 31, "byte seam R2");
  endtask

  task automatic t_best();
    fill(8'h00); mis_b[0] = 8'h1F; run_pass(1, 0, 31, "best a R7");   // 5
    fill(8'h00); mis_b[4] = 8'h07; run_pass(0, 0, 31, "best b R7");   // 3
    fill(8'h00); mis_b[7] = 8'hE0; run_pass(0, 0, 31, "tie R7");      // 3, keep 1
    fill(8'h00); mis_b[2] = 8'h7F; run_pass(0, 0, 31, "best d R6");   // 7
  endtask

  task automatic t_new_search();
    fill(8'h00); mis_b[0] = 8'hFF; mis_b[6] = 8'h03;
    run_pass(1, 0, 31, "new search R7");   // 10 replaces earlier best 3
  endtask

  task automatic t_reject();
    fill(8'h00); mis_b[0] = 8'hFF; mis_b[6] = 8'h03;
    run_pass(1, 0, 9, "above thr R8");
    run_pass(1, 0, 10, "equal thr R8");
  endtask

  task automatic t_saturate();
    fill(8'hFF);
    run_pass(1, 0, 31, "full raw R4");
    run_pass(1, 1, 31, "full clean R4");
  endtask

  task automatic t_stray();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      s_valid = 1; s_sop = 0; s_unk = 8'hFF; s_tpl = 8'h00;
      @(posedge clk);
    end
    @(negedge clk);
    s_valid = 0;
    @(negedge clk);
    check(res_valid == 0, "R5 stray beats no result", int'(res_valid), 0);
    fill(8'h00); mis_b[1] = 8'h03;
    run_pass(0, 0, 31, "after stray R5");
  endtask

  task automatic t_backpressure();
    fill(8'h00); mis_b[0] = 8'h01;
    for (int i = 0; i < NB; i++) begin
      @(negedge clk);
      s_valid = 1; s_sop = (i == 0); s_new_search = (i == 0);
      s_tpl = tpl_b[i]; s_unk = tpl_b[i] ^ mis_b[i]; cfg_denoise = 0;
      @(posedge clk);
    end
    @(negedge clk);
    s_valid = 0; s_sop = 0; s_new_search = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(s_ready == 0 && res_valid == 1, "R9 stall while pending",
            int'(s_ready), 0);
      check(res_count == 1, "R9 held count", int'(res_count), 1);
    end
    res_ready = 1;
    @(negedge clk);
    res_ready = 0;
    check(s_ready == 1, "R9 ready after take", int'(s_ready), 1);
    eb_cnt = 1; eb_idx = 0; nxt = 1; fresh = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_exact();
    t_dots();
    t_line_edge();
    t_best();
    t_new_search();
    t_reject();
    t_saturate();
    t_stray();
    t_backpressure();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule